// File: doc/BRIEF.md
# Write Port Block-Access Controller

This block is the write-side sequencer of a field FIFO. It runs on the write clock and watches four control inputs: a reset-write strobe, write enable, input enable and bit 0 of the data bus. It owns the write word pointer, and after each write-clock edge it tells the storage array whether a word is to be latched, whether that word may be committed (or is masked), and at which word address.

After a standard reset the pointer sits at the start of a 12-word cache region (address -12) and counts up one word per enabled edge. It wraps from the last array word to 0. A fixed control pattern on write enable and input enable during the four edges after a reset switches the block into random block access. A 13-bit block number is then shifted in serially, either on data bit 0 or on the input-enable pin. The choice is made by the write-enable level at edge 5. After a fixed latency the pointer jumps to the first word of that block. A long run with reset-write and write enable both high puts the block into a test state, and leaving that state follows its own rule.

States: WS_IDLE (no reset yet), WS_PATTERN (edges 1 to 4 after a reset), WS_SELECT (edge 5), WS_SHIFT (edges 6 to 17), WS_LATENCY (edges 18 to 35), WS_BLOCK (writing at the chosen block), WS_STANDARD (plain FIFO writing), WS_LOCKED (invalid block number) and WS_TEST. The transitions are as follows. A reset-write rise moves the block from any state except WS_TEST to WS_PATTERN. A pattern mismatch moves WS_PATTERN to WS_STANDARD. A match on edge 4 moves it to WS_SELECT. WS_SELECT always moves to WS_SHIFT. At edge 17, WS_SHIFT moves to WS_LATENCY if the block number is valid and to WS_LOCKED if not. The last latency edge moves WS_LATENCY to WS_BLOCK. A test run moves any state to WS_TEST. Leaving WS_TEST goes to WS_STANDARD.

Top module: `wport_blk_ctrl`

## Requirements
- R1: The first write-clock edge where reset-write is high after it was low at the previous edge sets the pointer to -12, whatever write enable is. That edge makes no strobe. Holding reset-write high does not repeat the reset. After chip reset the pointer is -12, and no strobe appears before the first reset-write.
- R2: Block entry needs input enable low and write enable high at edges 1 and 2 after the reset edge, then input enable high and write enable low at edges 3 and 4. A mismatch at any of these edges leaves the block in standard writing. Edges 1 to 4 themselves strobe and advance as in standard writing.
- R3: At edge 5, write enable low selects data bit 0 as the address pin, and write enable high selects the input-enable pin. The selected pin carries the block number MSB at that edge.
- R4: The other 12 block-number bits follow on edges 6 to 17, MSB first, with the LSB at edge 17. A block number is valid when it is below NUM_BLKS.
- R5: busy_o is high for exactly 18 cycles, from edge 17 up to edge 35. At edge 35 the pointer is loaded with block number times BLK_WORDS (40), and busy_o drops. blk_mode_o is high from edge 17 onward for a valid block number.
- R6: After each edge in standard, pattern or block writing where write enable is high, wr_stb_o is high for one cycle and wr_addr_o holds the pointer value from before that edge. wr_commit_o is high with it only if input enable was also high at that edge. Otherwise the word is masked.
- R7: Each such edge advances the pointer by one. The pointer wraps from NUM_BLKS*BLK_WORDS-1 to 0.
- R8: From edge 5 through edge 35 of a block entry, no strobe is made and write enable does not move the pointer.
- R9: An invalid block number gives a locked state. In it there are no strobes, the pointer is frozen, and busy_o and blk_mode_o are low. This lasts until the next reset-write rise, which acts as R1.
- R10: A reset-write rise during the entry sequence or the latency cancels block entry. It performs an R1 reset and clears busy_o and blk_mode_o.
- R11: On the 1024th consecutive edge with reset-write and write enable both high, test_mode_o goes high. While it is high, no strobe is made.
- R12: The test state is left at an edge where write enable is low, or at the second of two consecutive edges where reset-write is low. One low edge of reset-write alone keeps the test state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | write clock |
| rst_n | input | 1 | active-low chip reset |
| wrst_i | input | 1 | reset-write strobe |
| wen_i | input | 1 | write enable |
| ien_i | input | 1 | input enable (write mask when low) |
| din0_i | input | 1 | data bit 0, used as the serial address pin |
| wptr_o | output | PTR_W | signed write word pointer |
| wr_stb_o | output | 1 | word latch strobe for the previous edge |
| wr_commit_o | output | 1 | latched word may be committed |
| wr_addr_o | output | PTR_W | word address of the strobed word |
| blk_mode_o | output | 1 | random block access active |
| busy_o | output | 1 | block latency running |
| test_mode_o | output | 1 | test state active |

## Verification
The hardest situations to reach from the ports are the full 35-edge entry sequence done through each address pin, and the test state, which needs over a thousand unbroken edges of one input pattern. The bench drives the entry edge by edge through a task that takes the block number and the pin choice, and it ends one entry on an invalid number and cuts another short with a reset-write rise. For the test state it holds both controls high and checks the flag one edge before and exactly at the 1024th edge. It then checks both exit rules, including a single low reset-write edge that must not exit. A scoreboard catches any stray strobe during the frozen phases.

// File: rtl/wblk_pkg.sv
package wblk_pkg;
    typedef enum logic [3:0] {
        WS_IDLE,
        WS_PATTERN,
        WS_SELECT,
        WS_SHIFT,
        WS_LATENCY,
        WS_BLOCK,
        WS_STANDARD,
        WS_LOCKED,
        WS_TEST
    } wst_e;
endpackage

// File: rtl/wblk_rst_edge.sv
module wblk_rst_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rise_o,
    output logic low_twice_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= strobe_i;
    end

    assign rise_o      = strobe_i & ~prev_q;
    assign low_twice_o = ~strobe_i & ~prev_q;
endmodule

// File: rtl/wblk_test_watch.sv
module wblk_test_watch #(
    parameter int TEST_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wrst_i,
    input  logic wen_i,
    output logic hit_o
);
    localparam int RUN_W = $clog2(TEST_CYC + 1);

    logic [RUN_W-1:0] run_q;
    logic             both;

    assign both = wrst_i & wen_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          run_q <= '0;
        else if (!both)                      run_q <= '0;
        else if (run_q != RUN_W'(TEST_CYC))  run_q <= run_q + 1'b1;
    end

    assign hit_o = both && (run_q == RUN_W'(TEST_CYC - 1));

    AST_HIT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (run_q != '0 || TEST_CYC == 1)); // R11
endmodule

// File: rtl/wblk_addr_shift.sv
module wblk_addr_shift #(
    parameter int ADDR_BITS = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_i,
    input  logic                 bit_i,
    output logic [ADDR_BITS-1:0] addr_o,
    output logic [ADDR_BITS-1:0] nxt_o
);
    logic [ADDR_BITS-1:0] sr_q;

    assign nxt_o = {sr_q[ADDR_BITS-2:0], bit_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sr_q <= '0;
        else if (shift_i) sr_q <= nxt_o;
    end

    assign addr_o = sr_q;
endmodule

// File: rtl/wblk_wptr.sv
module wblk_wptr #(
    parameter int DEPTH       = 245760,
    parameter int PTR_W       = 19,
    parameter int CACHE_WORDS = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    load_i,
    input  logic signed [PTR_W-1:0] load_val_i,
    input  logic                    inc_i,
    output logic signed [PTR_W-1:0] ptr_o
);
    localparam logic signed [PTR_W-1:0] INIT = -(PTR_W'(CACHE_WORDS));
    localparam logic signed [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic signed [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ptr_q <= INIT;
        else if (clr_i)  ptr_q <= INIT;
        else if (load_i) ptr_q <= load_val_i;
        else if (inc_i)  ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'sb1;
    end

    assign ptr_o = ptr_q;

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_o >= INIT) && (ptr_o <= LAST)); // R7
endmodule

// File: rtl/wport_blk_ctrl.sv
module wport_blk_ctrl
    import wblk_pkg::*;
#(
    parameter int ADDR_BITS   = 13,
    parameter int NUM_BLKS    = 6144,
    parameter int BLK_WORDS   = 40,
    parameter int CACHE_WORDS = 12,
    parameter int LAT_CYC     = 18,
    parameter int TEST_CYC    = 1024,
    localparam int DEPTH      = NUM_BLKS * BLK_WORDS,
    localparam int PTR_W      = $clog2(DEPTH) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wrst_i,
    input  logic                    wen_i,
    input  logic                    ien_i,
    input  logic                    din0_i,
    output logic signed [PTR_W-1:0] wptr_o,
    output logic                    wr_stb_o,
    output logic                    wr_commit_o,
    output logic signed [PTR_W-1:0] wr_addr_o,
    output logic                    blk_mode_o,
    output logic                    busy_o,
    output logic                    test_mode_o
);
    localparam int PAT_LEN = 4;
    localparam int CNT_MAX = (LAT_CYC > ADDR_BITS) ? LAT_CYC : ADDR_BITS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1) + 1;
    localparam logic signed [PTR_W-1:0] PTR_INIT = -(PTR_W'(CACHE_WORDS));
    localparam logic signed [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    wst_e             state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             sel_q, sel_d;

    logic rst_rise, rst_low2, test_hit;
    logic ptr_clr, ptr_load, norm_edge, shift_en, shift_bit, pat_ok, blk_valid;
    logic [ADDR_BITS-1:0]    blk_num, blk_nxt;
    logic signed [PTR_W-1:0] load_val;

    logic                    stb_q, commit_q;
    logic signed [PTR_W-1:0] addr_q;

    wblk_rst_edge u_edge (
        .clk(clk), .rst_n(rst_n), .strobe_i(wrst_i),
        .rise_o(rst_rise), .low_twice_o(rst_low2)
    );

    wblk_test_watch #(.TEST_CYC(TEST_CYC)) u_test (
        .clk(clk), .rst_n(rst_n), .wrst_i(wrst_i), .wen_i(wen_i), .hit_o(test_hit)
    );

    wblk_addr_shift #(.ADDR_BITS(ADDR_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_i(shift_en), .bit_i(shift_bit),
        .addr_o(blk_num), .nxt_o(blk_nxt)
    );

    wblk_wptr #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CACHE_WORDS(CACHE_WORDS)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clr_i(ptr_clr), .load_i(ptr_load),
        .load_val_i(load_val), .inc_i(norm_edge && wen_i), .ptr_o(wptr_o)
    );

    // At edge 5 the pin choice is made from write enable itself.
    assign shift_bit = (state_q == WS_SELECT) ? (wen_i ? ien_i : din0_i)
                                              : (sel_q ? ien_i : din0_i);
    assign blk_valid = ({1'b0, blk_nxt} < (ADDR_BITS + 1)'(NUM_BLKS));
    assign load_val  = PTR_W'(blk_num) * PTR_W'(BLK_WORDS);
    assign pat_ok    = (cnt_q <= CNT_W'(2)) ? (!ien_i && wen_i) : (ien_i && !wen_i);

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        sel_d     = sel_q;
        ptr_clr   = 1'b0;
        ptr_load  = 1'b0;
        shift_en  = 1'b0;
        norm_edge = 1'b0;
        if (state_q == WS_TEST) begin
            if (!wen_i || rst_low2) state_d = WS_STANDARD;
        end else if (test_hit) begin
            state_d = WS_TEST;
        end else if (rst_rise) begin
            state_d = WS_PATTERN;
            cnt_d   = CNT_W'(1);
            ptr_clr = 1'b1;
        end else begin
            unique case (state_q)
                WS_STANDARD, WS_BLOCK: norm_edge = 1'b1;
                WS_PATTERN: begin
                    norm_edge = 1'b1;
                    if (!pat_ok)                         state_d = WS_STANDARD;
                    else if (cnt_q == CNT_W'(PAT_LEN))   state_d = WS_SELECT;
                    else                                 cnt_d   = cnt_q + 1'b1;
                end
                WS_SELECT: begin
                    sel_d    = wen_i;
                    shift_en = 1'b1;
                    cnt_d    = '0;
                    state_d  = WS_SHIFT;
                end
                WS_SHIFT: begin
                    shift_en = 1'b1;
                    if (cnt_q == CNT_W'(ADDR_BITS - 2)) begin
                        cnt_d   = '0;
                        state_d = blk_valid ? WS_LATENCY : WS_LOCKED;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                WS_LATENCY: begin
                    if (cnt_q == CNT_W'(LAT_CYC - 1)) begin
                        ptr_load = 1'b1;
                        state_d  = WS_BLOCK;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                WS_IDLE, WS_LOCKED, WS_TEST: begin
                end
                default: state_d = WS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            cnt_q   <= '0;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sel_q   <= sel_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q    <= 1'b0;
            commit_q <= 1'b0;
            addr_q   <= '0;
        end else begin
            stb_q    <= norm_edge && wen_i;
            commit_q <= norm_edge && wen_i && ien_i;
            if (norm_edge && wen_i) addr_q <= wptr_o;
        end
    end

    assign wr_stb_o    = stb_q;
    assign wr_commit_o = commit_q;
    assign wr_addr_o   = addr_q;
    assign blk_mode_o  = (state_q == WS_LATENCY) || (state_q == WS_BLOCK);
    assign busy_o      = (state_q == WS_LATENCY);
    assign test_mode_o = (state_q == WS_TEST);

    logic [CNT_W-1:0] busy_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_run_q <= '0;
        else if (busy_o) busy_run_q <= busy_run_q + 1'b1;
        else             busy_run_q <= '0;
    end

    AST_RST_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_rise && !test_hit && state_q != WS_TEST) |=> (wptr_o == PTR_INIT && !wr_stb_o)); // R1
    AST_LAT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && blk_mode_o) |-> (busy_run_q == CNT_W'(LAT_CYC))); // R5
    AST_BLK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && blk_mode_o) |-> (wptr_o >= 0 && (int'(wptr_o) % BLK_WORDS) == 0)); // R5
    AST_PTR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> (wptr_o == ((wr_addr_o == PTR_LAST) ? '0 : wr_addr_o + 1'sb1))); // R7
    AST_FROZEN_STB: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == WS_SELECT || state_q == WS_SHIFT || state_q == WS_LATENCY) && !rst_rise && !test_hit)
        |=> !wr_stb_o); // R8
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_LOCKED && !rst_rise && !test_hit) |=> ($stable(wptr_o) && !wr_stb_o)); // R9
    AST_TEST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode_o) |-> $past(wrst_i && wen_i)); // R11
    AST_TEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode_o |-> !wr_stb_o); // R11
endmodule

// File: tb/wport_blk_ctrl_tb.sv
module wport_blk_ctrl_tb;
    localparam int NB    = 16;
    localparam int BW    = 40;
    localparam int DEP   = NB * BW;
    localparam int PW    = $clog2(DEP) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wrst = 1'b0, wen = 1'b0, ien = 1'b0, din0 = 1'b0;
    logic signed [PW-1:0] wptr, waddr;
    logic stb, commit, blk, busy, tmode;

    int tot = 0;
    int bad = 0;
    int exp_ptr = -12;
    bit sb_on = 1'b1;
    int q_addr[$];
    bit q_com[$];

    always #10 clk = ~clk;

    wport_blk_ctrl #(.NUM_BLKS(NB), .BLK_WORDS(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wrst_i(wrst), .wen_i(wen), .ien_i(ien), .din0_i(din0),
        .wptr_o(wptr), .wr_stb_o(stb), .wr_commit_o(commit), .wr_addr_o(waddr),
        .blk_mode_o(blk), .busy_o(busy), .test_mode_o(tmode)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        tot++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Scoreboard monitor: every strobe must match the oldest expected word.
    always @(negedge clk) begin
        if (rst_n && sb_on && stb) begin
            if (q_addr.size() == 0) begin
                chk(1'b0, "R8 R9 unexpected strobe addr", int'(waddr), 0);
            end else begin
                int ea;
                bit ec;
                ea = q_addr.pop_front();
                ec = q_com.pop_front();
                chk(int'(waddr) == ea, "R6 R7 strobe address", int'(waddr), ea);
                chk(commit == ec, "R6 commit flag", int'(commit), int'(ec));
            end
        end
    end

    task automatic step(input bit r, input bit w, input bit i, input bit d);
        wrst = r; wen = w; ien = i; din0 = d;
        @(posedge clk);
        #5;
    endtask

    task automatic push_word(input bit i);
        q_addr.push_back(exp_ptr);
        q_com.push_back(i);
        exp_ptr = (exp_ptr == DEP - 1) ? 0 : exp_ptr + 1;
    endtask

    task automatic wr_word(input bit i);
        push_word(i);
        step(1'b0, 1'b1, i, 1'b0);
    endtask

    // Runs a block entry from the reset edge through edge 35 (or edge 17 if invalid).
    task automatic blk_entry(input int num, input bit use_ie, input bit valid);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        exp_ptr = -12;
        for (int k = 1; k <= 2; k++) begin
            push_word(1'b0);
            step(1'b0, 1'b1, 1'b0, 1'b0);
        end
        for (int k = 3; k <= 4; k++) step(1'b0, 1'b0, 1'b1, 1'b0);
        for (int k = 5; k <= 17; k++) begin
            bit b;
            b = num[17 - k];
            if (use_ie) step(1'b0, (k == 5), b, 1'b0);
            else        step(1'b0, 1'b0, 1'b0, b);
            if (k == 16) chk(busy == 1'b0, "R5 busy low before edge 17", int'(busy), 0);
        end
        chk(busy == valid, "R4 R5 busy after edge 17", int'(busy), int'(valid));
        chk(blk == valid, "R5 R9 block mode after edge 17", int'(blk), int'(valid));
        chk(int'(wptr) == -10, "R8 pointer frozen after edge 17", int'(wptr), -10);
        if (valid) begin
            for (int k = 18; k <= 34; k++) step(1'b0, 1'b0, 1'b0, 1'b0);
            chk(busy == 1'b1, "R5 busy held through edge 34", int'(busy), 1);
            step(1'b0, 1'b0, 1'b0, 1'b0);
            chk(busy == 1'b0, "R5 busy cleared after edge 35", int'(busy), 0);
            chk(blk == 1'b1, "R5 block mode after latency", int'(blk), 1);
            chk(int'(wptr) == num * BW, "R3 R5 pointer loaded", int'(wptr), num * BW);
            exp_ptr = num * BW;
        end
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", tot, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tot++;
        bad++;
        $display("FAIL watchdog R1-all actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        rst_n = 1'b1;
        chk(int'(wptr) == -12, "R1 pointer after chip reset", int'(wptr), -12);
        chk(!stb && !busy && !blk && !tmode, "R1 outputs idle after chip reset", int'(stb), 0);
        // R1: no strobe before the first reset-write
        step(1'b0, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk(int'(wptr) == -12, "R1 pointer idle before first reset", int'(wptr), -12);

        // R1, R6, R7: standard reset then writes with one masked word
        step(1'b1, 1'b0, 1'b0, 1'b0);
        exp_ptr = -12;
        chk(int'(wptr) == -12, "R1 reset edge pointer", int'(wptr), -12);
        wr_word(1'b1); wr_word(1'b1); wr_word(1'b0); wr_word(1'b1); wr_word(1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk(int'(wptr) == -7, "R7 pointer after five words", int'(wptr), -7);

        // R1: reset edge with write enable high makes no strobe; held high does not repeat
        step(1'b1, 1'b1, 1'b1, 1'b0);
        exp_ptr = -12;
        chk(int'(wptr) == -12, "R1 reset with write enable high", int'(wptr), -12);
        for (int n = 0; n < 3; n++) begin
            push_word(1'b1);
            step(1'b1, 1'b1, 1'b1, 1'b0);
        end
        chk(int'(wptr) == -9, "R1 held reset-write does not repeat", int'(wptr), -9);
        step(1'b0, 1'b0, 1'b0, 1'b0);

        // R2: pattern mismatch at edge 3 stays standard
        step(1'b1, 1'b0, 1'b0, 1'b0);
        exp_ptr = -12;
        push_word(1'b0); step(1'b0, 1'b1, 1'b0, 1'b0);
        push_word(1'b0); step(1'b0, 1'b1, 1'b0, 1'b0);
        push_word(1'b1); step(1'b0, 1'b1, 1'b1, 1'b0);
        for (int n = 0; n < 20; n++) step(1'b0, 1'b0, 1'b1, 1'b0);
        chk(!blk && !busy, "R2 mismatch leaves standard mode", int'(blk), 0);
        wr_word(1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk(int'(wptr) == -8, "R2 standard writing continues", int'(wptr), -8);

        // R3, R4, R5, R8: entry through data bit 0, block 5
        blk_entry(5, 1'b0, 1'b1);
        wr_word(1'b1); wr_word(1'b0); wr_word(1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk(int'(wptr) == 203, "R6 writes at new block", int'(wptr), 203);

        // R3, R4, R7: entry through input enable, last block 15, then wrap
        blk_entry(15, 1'b1, 1'b1);
        for (int n = 0; n < 41; n++) wr_word(1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk(int'(wptr) == 1, "R7 pointer wrap to 0", int'(wptr), 1);

        // R9: invalid block 16 locks until a reset-write rise
        blk_entry(16, 1'b0, 1'b0);
        for (int n = 0; n < 4; n++) step(1'b0, 1'b1, 1'b1, 1'b0);
        chk(int'(wptr) == -10, "R9 locked pointer frozen", int'(wptr), -10);
        chk(!busy && !blk, "R9 locked flags low", int'(busy), 0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        exp_ptr = -12;
        chk(int'(wptr) == -12, "R9 reset recovers lock", int'(wptr), -12);
        wr_word(1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0);

        // R10: cancel during address shifting, and during latency
        step(1'b1, 1'b0, 1'b0, 1'b0);
        exp_ptr = -12;
        push_word(1'b0); step(1'b0, 1'b1, 1'b0, 1'b0);
        push_word(1'b0); step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        for (int n = 0; n < 6; n++) step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        exp_ptr = -12;
        chk(int'(wptr) == -12 && !blk, "R10 cancel in shift phase", int'(wptr), -12);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        blk_entry(3, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        blk_entry(2, 1'b1, 1'b1);
        wr_word(1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk(int'(wptr) == 81, "R10 second entry after block run", int'(wptr), 81);

        // R10: reset-write rise in latency window
        step(1'b1, 1'b0, 1'b0, 1'b0);
        exp_ptr = -12;
        push_word(1'b0); step(1'b0, 1'b1, 1'b0, 1'b0);
        push_word(1'b0); step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        for (int n = 5; n <= 20; n++) step(1'b0, 1'b0, 1'b0, 1'b0);
        chk(busy == 1'b1, "R5 busy during latency", int'(busy), 1);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        exp_ptr = -12;
        chk(!busy && !blk && int'(wptr) == -12, "R10 cancel in latency", int'(busy), 0);
        step(1'b0, 1'b0, 1'b0, 1'b0);

        // R11, R12: test state
        step(1'b0, 1'b0, 1'b0, 1'b0);
        sb_on = 1'b0;
        for (int n = 0; n < 1023; n++) step(1'b1, 1'b1, 1'b0, 1'b0);
        chk(tmode == 1'b0, "R11 no test state at 1023 edges", int'(tmode), 0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        chk(tmode == 1'b1, "R11 test state at 1024 edges", int'(tmode), 1);
        chk(stb == 1'b0, "R11 strobe suppressed on entry", int'(stb), 0);
        step(1'b1, 1'b1, 1'b1, 1'b0);
        chk(stb == 1'b0 && tmode, "R11 strobe suppressed in test", int'(stb), 0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        chk(tmode == 1'b0, "R12 exit on write enable low", int'(tmode), 0);
        for (int n = 0; n < 1024; n++) step(1'b1, 1'b1, 1'b0, 1'b0);
        chk(tmode == 1'b1, "R11 test state re-entered", int'(tmode), 1);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        chk(tmode == 1'b1, "R12 one low reset-write edge keeps test", int'(tmode), 1);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        chk(tmode == 1'b0, "R12 two low reset-write edges exit", int'(tmode), 0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        q_addr.delete();
        q_com.delete();
        sb_on = 1'b1;
        step(1'b1, 1'b0, 1'b0, 1'b0);
        exp_ptr = -12;
        wr_word(1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk(int'(wptr) == -11, "R1 reset after test state", int'(wptr), -11);

        chk(q_addr.size() == 0, "R6 all expected strobes seen", q_addr.size(), 0);
        finish_run();
    end
endmodule